// File: doc/BRIEF.md
# Parallel Bus Master Controller

This block is the master side of an external 8-bit parallel bus with up to 16 address bits. A host inside the chip requests a single read or write by pulsing `start` with a direction, an optional new address and one or two write bytes. The controller then walks through optional address-latch cycles, and a setup, strobe and hold stage for each data byte. While it does this it drives the data bus, the address outputs, the strobes, the byte-enable line and up to two chip selects. When the access ends it reports completion with a one-cycle `done` pulse.

The bus side can be set up in several ways through static configuration inputs, which are changed only while the block is idle. The strobes come in two styles. In the combined style, a direction line plus an enable strobe mark the access. In the split style, separate read and write strobes are used. The address can be fully separated from the data bus, or it can be sent over the data bus ahead of the data in one or two latch cycles. Transfers are 8 or 16 bits wide, and every control line has a selectable polarity. The address pointer can also step up or down after each access, so that block transfers need no new address.

Top module: `par_bus_master`

## Requirements
- R1: After reset, `busy`, `done` and `bus_oe` are 0. Every strobe, latch, byte-enable and chip-select output sits at its inactive level: high when its polarity input is 0, low when it is 1.
- R2: `start` is accepted only when `busy` is 0. A `start` given while `busy` is 1 changes neither the running access nor the address, and it starts no further access.
- R3: `busy` goes high in the cycle after an accepted `start`. Each byte takes (setup+1)+(strobe+1)+(hold+1) cycles, where each stage count is 0 to 15. After the last hold cycle, `busy` falls and `done` is high for exactly one cycle.
- R4: In the combined style (`cfg_split`=0), `bus_rd_rw` is active through all data stages of a read and inactive for a write. `bus_wr_en` is active only in the strobe stage, for both directions.
- R5: In the split style (`cfg_split`=1), `bus_rd_rw` is active only in the strobe stage of a read, and `bus_wr_en` is active only in the strobe stage of a write.
- R6: Each polarity input set to 1 makes its line active-high; set to 0, it makes the line active-low. `cfg_pol_rd` governs the read/direction pin and `cfg_pol_wr` governs the write/enable pin in both styles.
- R7: With `cfg_wide`=1, a transfer uses two byte sequences, low byte first. `bus_be` is active through the setup, strobe and hold stages of the high byte only.
- R8: With `cfg_mux`=1, one latch cycle comes before the data stages. In it, `bus_oe`=1, `bus_dout` carries the low address byte and `bus_all` is active. `bus_addr` carries the high address byte in bits 15:8 and 0 in bits 7:0.
- R9: With `cfg_mux`=2, a low-latch cycle (`bus_all`) comes first and is followed by a high-latch cycle (`bus_alh`) that carries the high address byte on `bus_dout`. `bus_addr` is 0. With `cfg_mux`=0, `bus_addr` carries the whole address and there are no latch cycles.
- R10: When `cfg_cs_en[i]` is 1, chip select i is active during an access whose address bit 14+i is 1, and that address bit is driven as 0 on every address output.
- R11: After each access, the address steps by +1 when `cfg_step`=1 and by -1 when `cfg_step`=2, wrapping at 16 bits. Otherwise it stays the same. A `start` with `req_load`=1 replaces the address with `req_addr`.
- R12: Read bytes are sampled from `bus_din` in the last cycle of each strobe stage. `rd_data` is cleared at an accepted start and is valid when `done` is high: the low byte is in bits 7:0, and the high byte is in bits 15:8 (0 for 8-bit transfers).
- R13: During the data stages of a write, `bus_oe`=1 and `bus_dout` carries the current byte. During the data stages of a read, and while idle, `bus_oe`=0 and `bus_dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse |
| req_read | input | 1 | 1 = read, 0 = write |
| req_load | input | 1 | Load `req_addr` into the address pointer |
| req_addr | input | 16 | New address |
| req_wdata | input | 16 | Write bytes (low byte in 7:0) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read bytes |
| cfg_split | input | 1 | 0 = direction plus enable, 1 = separate read and write strobes |
| cfg_wide | input | 1 | 1 = 16-bit transfers |
| cfg_mux | input | 2 | 0 = separate address, 1 = low byte on data bus, 2 = both bytes on data bus |
| cfg_step | input | 2 | 0 = hold, 1 = increment, 2 = decrement |
| cfg_cs_en | input | 2 | Use address bit 14+i as chip select i |
| cfg_wait_setup | input | 4 | Extra setup cycles |
| cfg_wait_strobe | input | 4 | Extra strobe cycles |
| cfg_wait_hold | input | 4 | Extra hold cycles |
| cfg_pol_rd | input | 1 | Polarity of read/direction pin |
| cfg_pol_wr | input | 1 | Polarity of write/enable pin |
| cfg_pol_be | input | 1 | Polarity of byte enable |
| cfg_pol_al | input | 1 | Polarity of both address latches |
| cfg_pol_cs | input | 1 | Polarity of chip selects |
| bus_din | input | 8 | Data bus input |
| bus_dout | output | 8 | Data bus output |
| bus_oe | output | 1 | Data bus drive enable |
| bus_addr | output | 16 | Address outputs |
| bus_rd_rw | output | 1 | Read strobe or direction line |
| bus_wr_en | output | 1 | Write strobe or enable strobe |
| bus_be | output | 1 | High-byte enable |
| bus_all | output | 1 | Low address latch |
| bus_alh | output | 1 | High address latch |
| bus_cs | output | 2 | Chip selects |

## Verification
The cycle that ends an access also applies the address step. That same cycle is the first one in which a new `start` can be accepted, so stepping and acceptance meet there. The bench provokes this by issuing back-to-back requests without a new address. The reference model advances its own address copy at `done` and expects the next access to drive the stepped value, with chip selects and masked bits taken from it. The other clash is a `start` that arrives during a busy access, with a different direction and a new address. It is judged by comparing every pin on every following cycle against the unchanged expected sequence, and by checking that no further access begins.

// File: rtl/pbm_pkg.sv
`timescale 1ns/1ps
// Shared types for the parallel bus master.
// Assumes: nothing; holds only the phase encoding and mode codes.
package pbm_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALO,
        PH_AHI,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_t;

    localparam logic [1:0] MUX_NONE  = 2'd0;
    localparam logic [1:0] MUX_LOW   = 2'd1;
    localparam logic [1:0] STEP_UP   = 2'd1;
    localparam logic [1:0] STEP_DOWN = 2'd2;
endpackage

// File: rtl/pbm_seq.sv
`timescale 1ns/1ps
// Access sequencer: steps through the latch cycles, then the setup, strobe
// and hold stages for each byte, counting down the programmed wait cycles.
// Assumes: the mode and wait inputs stay stable while busy.
module pbm_seq
    import pbm_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_read,
    input  logic [1:0]        mux_mode,
    input  logic              wide,
    input  logic [WAIT_W-1:0] wait_setup,
    input  logic [WAIT_W-1:0] wait_strobe,
    input  logic [WAIT_W-1:0] wait_hold,
    output phase_t            phase,
    output logic              byte_hi,
    output logic              is_read,
    output logic              busy,
    output logic              done,
    output logic              acc_end,
    output logic              capture
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    logic [WAIT_W-1:0] cnt;
    logic              last;

    // Decode stage-end, access-end and read-capture conditions.
    assign last    = (cnt == '0);
    assign busy    = (phase != PH_IDLE);
    assign acc_end = (phase == PH_HOLD) && last && (!wide || byte_hi);
    assign capture = (phase == PH_STROBE) && last && is_read;

    // Phase register, wait counter and per-access flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            byte_hi <= 1'b0;
            is_read <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= acc_end;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        is_read <= req_read;
                        byte_hi <= 1'b0;
                        if (mux_mode != MUX_NONE) begin
                            phase <= PH_ALO;
                            cnt   <= '0;
                        end else begin
                            phase <= PH_SETUP;
                            cnt   <= wait_setup;
                        end
                    end
                end
                PH_ALO: begin
                    if (mux_mode[1]) begin
                        phase <= PH_AHI;
                    end else begin
                        phase <= PH_SETUP;
                        cnt   <= wait_setup;
                    end
                end
                PH_AHI: begin
                    phase <= PH_SETUP;
                    cnt   <= wait_setup;
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_STROBE;
                        cnt   <= wait_strobe;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= wait_hold;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        if (wide && !byte_hi) begin
                            byte_hi <= 1'b1;
                            phase   <= PH_SETUP;
                            cnt     <= wait_setup;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase == PH_IDLE && $past(phase) == PH_HOLD)); // R3
    AST_HIGH_LATCH_FULL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ALO) |=> ((phase == PH_AHI) == mux_mode[1])); // R9
    AST_BUSY_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !acc_end) |=> busy); // R2
endmodule

// File: rtl/pbm_addr.sv
`timescale 1ns/1ps
// Address pointer: loads on request, steps after each access, and turns
// the selected upper bits into chip selects while forcing them to 0.
// Assumes: load and step never coincide (load only when idle).
module pbm_addr
    import pbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_en,
    input  logic [1:0]        step_mode,
    input  logic [NUM_CS-1:0] cs_en,
    input  logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] drv_addr,
    output logic [NUM_CS-1:0] cs_act
);
    localparam int CS_BASE = ADDR_W - NUM_CS;
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] cs_mask;

    // Build the chip-select mask and active flags, one per select.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_mask[CS_BASE+i] = cs_en[i];
        assign cs_act[i]          = busy & cs_en[i] & cur_addr[CS_BASE+i];
    end
    if (CS_BASE > 0) begin : g_low
        assign cs_mask[CS_BASE-1:0] = '0;
    end

    // Clear address bits that serve as chip selects.
    assign drv_addr = cur_addr & ~cs_mask;

    // Address pointer: load, step up, step down or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (load) begin
            cur_addr <= load_val;
        end else if (step_en) begin
            if (step_mode == STEP_UP)
                cur_addr <= cur_addr + ONE;
            else if (step_mode == STEP_DOWN)
                cur_addr <= cur_addr - ONE;
        end
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && step_mode == STEP_UP) |=> (cur_addr == $past(cur_addr) + ONE)); // R11
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load && step_mode == STEP_DOWN) |=> (cur_addr == $past(cur_addr) - ONE)); // R11
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step_en) |=> $stable(cur_addr)); // R11
endmodule

// File: rtl/pbm_pins.sv
`timescale 1ns/1ps
// Pin driver: turns the current phase into active flags per line, applies
// polarity, and selects what the data and address outputs carry.
// Assumes: address width is twice the data width.
module pbm_pins
    import pbm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_CS = 2
) (
    input  phase_t              phase,
    input  logic                is_read,
    input  logic                byte_hi,
    input  logic                wide,
    input  logic                split,
    input  logic [1:0]          mux_mode,
    input  logic [2*DATA_W-1:0] drv_addr,
    input  logic [2*DATA_W-1:0] wdata,
    input  logic [NUM_CS-1:0]   cs_act,
    input  logic                pol_rd,
    input  logic                pol_wr,
    input  logic                pol_be,
    input  logic                pol_al,
    input  logic                pol_cs,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_oe,
    output logic [2*DATA_W-1:0] bus_addr,
    output logic                bus_rd_rw,
    output logic                bus_wr_en,
    output logic                bus_be,
    output logic                bus_all,
    output logic                bus_alh,
    output logic [NUM_CS-1:0]   bus_cs
);
    logic data_ph, strobe_ph, a_rd, a_wr, a_be;

    // Active flags per line, chosen by strobe style.
    always_comb begin
        data_ph   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
        strobe_ph = (phase == PH_STROBE);
        a_rd      = split ? (strobe_ph & is_read) : (data_ph & is_read);
        a_wr      = split ? (strobe_ph & ~is_read) : strobe_ph;
        a_be      = wide & byte_hi & data_ph;
    end

    // Polarity: a set bit means active-high.
    assign bus_rd_rw = ~(a_rd ^ pol_rd);
    assign bus_wr_en = ~(a_wr ^ pol_wr);
    assign bus_be    = ~(a_be ^ pol_be);
    assign bus_all   = ~((phase == PH_ALO) ^ pol_al);
    assign bus_alh   = ~((phase == PH_AHI) ^ pol_al);
    assign bus_cs    = ~(cs_act ^ {NUM_CS{pol_cs}});

    // Data bus source: address bytes in latch cycles, write bytes in data stages.
    always_comb begin
        bus_dout = '0;
        bus_oe   = 1'b0;
        if (phase == PH_ALO) begin
            bus_dout = drv_addr[DATA_W-1:0];
            bus_oe   = 1'b1;
        end else if (phase == PH_AHI) begin
            bus_dout = drv_addr[2*DATA_W-1:DATA_W];
            bus_oe   = 1'b1;
        end else if (data_ph && !is_read) begin
            bus_dout = byte_hi ? wdata[2*DATA_W-1:DATA_W] : wdata[DATA_W-1:0];
            bus_oe   = 1'b1;
        end
    end

    // Address outputs: bytes that travel on the data bus read as 0 here.
    always_comb begin
        if (mux_mode == MUX_NONE)
            bus_addr = drv_addr;
        else if (mux_mode == MUX_LOW)
            bus_addr = {drv_addr[2*DATA_W-1:DATA_W], {DATA_W{1'b0}}};
        else
            bus_addr = '0;
    end
endmodule

// File: rtl/par_bus_master.sv
`timescale 1ns/1ps
// Parallel bus master top: accepts a host request, latches the write bytes,
// runs the sequencer, and gathers read bytes into rd_data.
// Assumes: cfg_* inputs change only while busy is low.
module par_bus_master
    import pbm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WAIT_W = 4,
    parameter int NUM_CS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  req_read,
    input  logic                  req_load,
    input  logic [2*DATA_W-1:0]   req_addr,
    input  logic [2*DATA_W-1:0]   req_wdata,
    output logic                  busy,
    output logic                  done,
    output logic [2*DATA_W-1:0]   rd_data,
    input  logic                  cfg_split,
    input  logic                  cfg_wide,
    input  logic [1:0]            cfg_mux,
    input  logic [1:0]            cfg_step,
    input  logic [NUM_CS-1:0]     cfg_cs_en,
    input  logic [WAIT_W-1:0]     cfg_wait_setup,
    input  logic [WAIT_W-1:0]     cfg_wait_strobe,
    input  logic [WAIT_W-1:0]     cfg_wait_hold,
    input  logic                  cfg_pol_rd,
    input  logic                  cfg_pol_wr,
    input  logic                  cfg_pol_be,
    input  logic                  cfg_pol_al,
    input  logic                  cfg_pol_cs,
    input  logic [DATA_W-1:0]     bus_din,
    output logic [DATA_W-1:0]     bus_dout,
    output logic                  bus_oe,
    output logic [2*DATA_W-1:0]   bus_addr,
    output logic                  bus_rd_rw,
    output logic                  bus_wr_en,
    output logic                  bus_be,
    output logic                  bus_all,
    output logic                  bus_alh,
    output logic [NUM_CS-1:0]     bus_cs
);
    localparam int ADDR_W = 2 * DATA_W;

    phase_t              phase;
    logic                byte_hi, is_read, acc_end, capture, accept;
    logic [ADDR_W-1:0]   cur_addr, drv_addr;
    logic [NUM_CS-1:0]   cs_act;
    logic [2*DATA_W-1:0] wdata_q;

    assign accept = start & ~busy;

    pbm_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .req_read(req_read),
        .mux_mode(cfg_mux), .wide(cfg_wide),
        .wait_setup(cfg_wait_setup), .wait_strobe(cfg_wait_strobe), .wait_hold(cfg_wait_hold),
        .phase(phase), .byte_hi(byte_hi), .is_read(is_read), .busy(busy),
        .done(done), .acc_end(acc_end), .capture(capture)
    );

    pbm_addr #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(accept & req_load), .load_val(req_addr),
        .step_en(acc_end), .step_mode(cfg_step), .cs_en(cfg_cs_en), .busy(busy),
        .cur_addr(cur_addr), .drv_addr(drv_addr), .cs_act(cs_act)
    );

    pbm_pins #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_pins (
        .phase(phase), .is_read(is_read), .byte_hi(byte_hi), .wide(cfg_wide),
        .split(cfg_split), .mux_mode(cfg_mux), .drv_addr(drv_addr), .wdata(wdata_q),
        .cs_act(cs_act), .pol_rd(cfg_pol_rd), .pol_wr(cfg_pol_wr), .pol_be(cfg_pol_be),
        .pol_al(cfg_pol_al), .pol_cs(cfg_pol_cs),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_addr(bus_addr),
        .bus_rd_rw(bus_rd_rw), .bus_wr_en(bus_wr_en), .bus_be(bus_be),
        .bus_all(bus_all), .bus_alh(bus_alh), .bus_cs(bus_cs)
    );

    // Latch write bytes when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (accept)
            wdata_q <= req_wdata;
    end

    // Clear read data at acceptance; store each byte at the end of its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (accept)
            rd_data <= '0;
        else if (capture) begin
            if (byte_hi)
                rd_data[2*DATA_W-1:DATA_W] <= bus_din;
            else
                rd_data[DATA_W-1:0] <= bus_din;
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rd_data)); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
endmodule

// File: tb/par_bus_master_tb.sv
`timescale 1ns/1ps
module par_bus_master_tb;
    typedef struct packed {
        logic       rdrw, wren, be, all, alh;
        logic [1:0] cs;
        logic       oe;
        logic [7:0] dout;
        logic [15:0] addr;
        logic [7:0] din;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, req_read = 0, req_load = 0;
    logic [15:0] req_addr = 0, req_wdata = 0;
    logic busy, done, bus_oe, bus_rd_rw, bus_wr_en, bus_be, bus_all, bus_alh;
    logic [15:0] rd_data, bus_addr;
    logic [7:0] bus_din = 8'hEE, bus_dout;
    logic [1:0] bus_cs;
    logic cfg_split = 0, cfg_wide = 0;
    logic [1:0] cfg_mux = 0, cfg_step = 1, cfg_cs_en = 0;
    logic [3:0] ws = 0, wst = 0, wh = 0;
    logic p_rd = 0, p_wr = 1, p_be = 1, p_al = 1, p_cs = 1;

    int tests = 0, fails = 0;
    logic [15:0] model_addr = 16'h0000;

    always #2 clk = ~clk;

    par_bus_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_read(req_read), .req_load(req_load),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .cfg_split(cfg_split), .cfg_wide(cfg_wide), .cfg_mux(cfg_mux), .cfg_step(cfg_step),
        .cfg_cs_en(cfg_cs_en), .cfg_wait_setup(ws), .cfg_wait_strobe(wst), .cfg_wait_hold(wh),
        .cfg_pol_rd(p_rd), .cfg_pol_wr(p_wr), .cfg_pol_be(p_be), .cfg_pol_al(p_al),
        .cfg_pol_cs(p_cs), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_rd_rw(bus_rd_rw), .bus_wr_en(bus_wr_en), .bus_be(bus_be),
        .bus_all(bus_all), .bus_alh(bus_alh), .bus_cs(bus_cs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic lv(input logic act, input logic pol);
        return pol ? act : ~act;
    endfunction

    // Reference record for a cycle with no latch or data stage active.
    function automatic exp_t mk_base(input logic [15:0] a, input logic act);
        exp_t r;
        logic [15:0] da;
        da = a;
        if (cfg_cs_en[0]) da[14] = 1'b0;
        if (cfg_cs_en[1]) da[15] = 1'b0;
        r.rdrw = lv(1'b0, p_rd);
        r.wren = lv(1'b0, p_wr);
        r.be   = lv(1'b0, p_be);
        r.all  = lv(1'b0, p_al);
        r.alh  = lv(1'b0, p_al);
        r.cs[0] = lv(act & cfg_cs_en[0] & a[14], p_cs);
        r.cs[1] = lv(act & cfg_cs_en[1] & a[15], p_cs);
        r.oe   = 1'b0;
        r.dout = 8'h00;
        r.din  = 8'hEE;
        if (cfg_mux == 2'd0)      r.addr = da;
        else if (cfg_mux == 2'd1) r.addr = {da[15:8], 8'h00};
        else                      r.addr = 16'h0000;
        return r;
    endfunction

    task automatic cmp(input exp_t r, input logic eb, input logic ed);
        chk("R4 R5 R6 rd/dir line", bus_rd_rw, r.rdrw);
        chk("R4 R5 R6 wr/enable line", bus_wr_en, r.wren);
        chk("R7 byte enable", bus_be, r.be);
        chk("R8 low latch", bus_all, r.all);
        chk("R9 high latch", bus_alh, r.alh);
        chk("R10 chip selects", bus_cs, r.cs);
        chk("R13 drive enable", bus_oe, r.oe);
        chk("R13 R8 data out", bus_dout, r.dout);
        chk("R9 R10 R11 address", bus_addr, r.addr);
        chk("R2 R3 busy", busy, eb);
        chk("R3 done", done, ed);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            bus_din = 8'hEE;
            cmp(mk_base(model_addr, 1'b0), 1'b0, 1'b0);
        end
    endtask

    // Starts at a negedge with the block idle; returns at the done negedge.
    task automatic access(input logic rd, input logic ld, input logic [15:0] a,
                          input logic [15:0] w, input logic [7:0] rb0,
                          input logic [7:0] rb1, input int ign);
        exp_t q[$];
        exp_t r, b;
        logic [15:0] da, exp_rd;
        int n;
        if (ld) model_addr = a;
        da = model_addr;
        if (cfg_cs_en[0]) da[14] = 1'b0;
        if (cfg_cs_en[1]) da[15] = 1'b0;
        b = mk_base(model_addr, 1'b1);
        if (cfg_mux != 2'd0) begin
            r = b; r.all = lv(1'b1, p_al); r.oe = 1'b1; r.dout = da[7:0]; q.push_back(r);
        end
        if (cfg_mux[1]) begin
            r = b; r.alh = lv(1'b1, p_al); r.oe = 1'b1; r.dout = da[15:8]; q.push_back(r);
        end
        for (int by = 0; by < (cfg_wide ? 2 : 1); by++) begin
            for (int st = 0; st < 3; st++) begin
                n = (st == 0) ? int'(ws) : (st == 1) ? int'(wst) : int'(wh);
                for (int k = 0; k <= n; k++) begin
                    r = b;
                    r.be = lv(cfg_wide && by == 1, p_be);
                    if (cfg_split) begin
                        r.rdrw = lv(rd && st == 1, p_rd);
                        r.wren = lv(!rd && st == 1, p_wr);
                    end else begin
                        r.rdrw = lv(rd, p_rd);
                        r.wren = lv(st == 1, p_wr);
                    end
                    r.oe = !rd;
                    r.dout = rd ? 8'h00 : (by == 1 ? w[15:8] : w[7:0]);
                    if (st == 1 && k == n) r.din = (by == 1) ? rb1 : rb0;
                    q.push_back(r);
                end
            end
        end
        exp_rd = rd ? {(cfg_wide ? rb1 : 8'h00), rb0} : 16'h0000;
        start = 1'b1; req_read = rd; req_load = ld; req_addr = a; req_wdata = w;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            bus_din = q[i].din;
            if (i == ign) begin
                start = 1'b1; req_read = ~rd; req_load = 1'b1;
                req_addr = 16'h1234; req_wdata = 16'h9999;
            end else begin
                start = 1'b0;
            end
            cmp(q[i], 1'b1, 1'b0);
            @(negedge clk);
        end
        start = 1'b0;
        bus_din = 8'hEE;
        if (cfg_step == 2'd1) model_addr = model_addr + 16'd1;
        else if (cfg_step == 2'd2) model_addr = model_addr - 16'd1;
        chk("R12 read data at done", rd_data, exp_rd);
        cmp(mk_base(model_addr, 1'b0), 1'b0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with an active-low read line
        cmp(mk_base(model_addr, 1'b0), 1'b0, 1'b0);
        chk("R1 drive enable after reset", bus_oe, 1'b0);
        chk("R1 rd/dir idle level", bus_rd_rw, 1'b1);
        idle(1);
        // R4 R13 combined-style 8-bit write, no waits, R11 step up
        access(1'b0, 1'b1, 16'h0010, 16'h00A5, 8'h00, 8'h00, -1);
        idle(2);
        // R3 R12 read with waits, R2 start ignored mid-access
        ws = 4'd2; wst = 4'd3; wh = 4'd1;
        idle(1);
        access(1'b1, 1'b0, 16'h0000, 16'h0000, 8'h3C, 8'h00, 4);
        idle(3);
        // R5 R6 R7 R8 split style, 16-bit, low byte multiplexed, all active-low, step down
        cfg_split = 1; cfg_wide = 1; cfg_mux = 2'd1; cfg_step = 2'd2;
        p_rd = 0; p_wr = 0; p_be = 0; p_al = 0; p_cs = 0;
        ws = 4'd1; wst = 4'd0; wh = 4'd0;
        idle(1);
        access(1'b0, 1'b1, 16'h2345, 16'hBEEF, 8'h00, 8'h00, -1);
        idle(1);
        // R9 R12 full multiplexing, 16-bit reads back to back with R11 stepping
        cfg_mux = 2'd2; cfg_step = 2'd1; p_rd = 1; p_wr = 1; p_be = 1; p_al = 1;
        ws = 4'd0; wst = 4'd1; wh = 4'd0;
        idle(1);
        access(1'b1, 1'b1, 16'h8001, 16'h0000, 8'h11, 8'h22, 3);
        access(1'b1, 1'b0, 16'h0000, 16'h0000, 8'h33, 8'h44, -1);
        idle(2);
        // R10 chip selects, combined style, step down across back-to-back accesses
        cfg_split = 0; cfg_wide = 0; cfg_mux = 2'd0; cfg_cs_en = 2'b11; cfg_step = 2'd2;
        p_cs = 1; p_rd = 0;
        idle(1);
        access(1'b0, 1'b1, 16'hC0F3, 16'h005A, 8'h00, 8'h00, -1);
        access(1'b1, 1'b0, 16'h0000, 16'h0000, 8'h66, 8'h00, -1);
        idle(1);
        // R11 wrap below zero, then R10 select from the wrapped address
        cfg_cs_en = 2'b01; p_cs = 0;
        idle(1);
        access(1'b0, 1'b1, 16'h0000, 16'h0077, 8'h00, 8'h00, -1);
        chk("R11 wrap to all ones on address pins", bus_addr, 16'hBFFF);
        access(1'b1, 1'b0, 16'h0000, 16'h0000, 8'h5D, 8'h00, -1);
        idle(1);
        // R11 hold mode keeps the address
        cfg_step = 2'd0; cfg_cs_en = 2'b00; cfg_mux = 2'd1;
        idle(1);
        access(1'b0, 1'b1, 16'h0777, 16'h00C3, 8'h00, 8'h00, -1);
        access(1'b0, 1'b0, 16'h0000, 16'h003C, 8'h00, 8'h00, -1);
        idle(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule